// File: doc/BRIEF.md
# Programmable LED Blinker with Long-Gap Insertion

This block drives a single indicator LED in one of three modes: dark, lit, or flashing. In flashing mode the lit time and the dark time are programmed separately. A group length N and a gap length can also be set. After every N complete lit/dark cycles, the block holds the LED dark for one extra gap, then starts the next group. All durations are counted in pulses of a 1/16-second tick input, which is supplied from outside the block.

A write strobe loads the mode and all four timing fields in one cycle. Every write restarts the pattern at the first tick of a lit interval. A blanking input, raised on a battery fault, forces the LED dark and drops the activity flag while keeping the stored settings. When blanking is released, the same pattern starts again from the beginning. The activity flag tells the power controller that the LED needs the clock running.

Top module: `led_pattern_gen`

## Requirements
- R1: After reset the stored mode is dark, and `led` and `busy` are both 0.
- R2: Mode code 2'b00 is dark: `led`=0 and `busy`=0. Mode code 2'b01 is lit: `led`=1, and `tick` has no effect on it. Codes 2'b10 and 2'b11 select flashing.
- R3: In flashing mode the LED is lit for `on` ticks and then dark for `off` ticks. A field moves to its next interval only on a cycle where `tick` is high.
- R4: With group length N greater than 0, the dark interval that ends the Nth cycle is followed by a dark gap of `gap` ticks. After the gap a new lit interval begins and the cycle count starts again from zero.
- R5: A group length of 0 disables the gap, so lit and dark intervals simply alternate.
- R6: An interval field of 0 behaves as a length of one tick.
- R7: A write takes effect in the cycle after `wr_en`. In flashing mode the LED is then lit at the start of an on-interval, with all counters cleared, and any `tick` arriving in the write cycle is ignored.
- R8: While `blank` is high, `led` and `busy` are 0 in the same cycle, and the stored settings do not change unless a write occurs.
- R9: Writes made while `blank` is high are accepted. When `blank` falls, the pattern in force starts from the beginning of an on-interval.
- R10: `busy` is 1 exactly when `blank` is low and the mode is lit or flashing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse every 1/16 s |
| wr_en | input | 1 | Load all settings |
| wr_mode | input | 2 | Mode code: 00 dark, 01 lit, 1x flashing |
| wr_on | input | IVL_W | Lit interval, in ticks |
| wr_off | input | IVL_W | Dark interval, in ticks |
| wr_group | input | GRP_W | Cycles per group; 0 disables the gap |
| wr_gap | input | IVL_W | Gap interval, in ticks |
| blank | input | 1 | Battery fault: force dark and hold settings |
| led | output | 1 | LED drive, active high |
| busy | output | 1 | LED needs the clock running |

## Verification
A wrong phase, interval count or cycle count inside the sequencer shows up on `led` at the next tick boundary, so an off-by-one lit or dark run is visible within a single interval. A cycle counter that miscounts changes where the long dark gap falls, which shows up within one group. Errors in the blanking path or the mode decode appear on `led` or `busy` in the very cycle they occur. The reference model is compared against the outputs on every clock, so the first cycle that deviates is the one reported.

// File: rtl/led_pat_pkg.sv
package led_pat_pkg;

  typedef enum logic [1:0] {
    PH_LIT  = 2'd0,
    PH_DARK = 2'd1,
    PH_GAP  = 2'd2
  } phase_e;

  localparam logic [1:0] MODE_DARK = 2'b00;
  localparam logic [1:0] MODE_LIT  = 2'b01;

  // Flashing is selected by the upper mode bit.
  function automatic logic is_flash(input logic [1:0] m);
    return m[1];
  endfunction

  // A field of zero is stretched to a single tick.
  function automatic int unsigned eff_ticks(input int unsigned f);
    return (f == 0) ? 1 : f;
  endfunction

endpackage

// File: rtl/led_cfg.sv
module led_cfg #(
  parameter int IVL_W = 8,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [IVL_W-1:0] wr_on,
  input  logic [IVL_W-1:0] wr_off,
  input  logic [GRP_W-1:0] wr_group,
  input  logic [IVL_W-1:0] wr_gap,
  output logic [1:0]       mode,
  output logic [IVL_W-1:0] on_ivl,
  output logic [IVL_W-1:0] off_ivl,
  output logic [GRP_W-1:0] group_n,
  output logic [IVL_W-1:0] gap_ivl
);
  import led_pat_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= MODE_DARK;
      on_ivl  <= '0;
      off_ivl <= '0;
      group_n <= '0;
      gap_ivl <= '0;
    end else if (wr_en) begin
      mode    <= wr_mode;
      on_ivl  <= wr_on;
      off_ivl <= wr_off;
      group_n <= wr_group;
      gap_ivl <= wr_gap;
    end
  end

  // Settings only move on a write (blanking keeps them).
  assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(mode) && $stable(on_ivl) && $stable(off_ivl)
                && $stable(group_n) && $stable(gap_ivl)));

endmodule

// File: rtl/led_seq.sv
module led_seq #(
  parameter int IVL_W = 8,
  parameter int GRP_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     restart,
  input  logic                     run,
  input  logic                     tick,
  input  logic [IVL_W-1:0]         on_ivl,
  input  logic [IVL_W-1:0]         off_ivl,
  input  logic [GRP_W-1:0]         group_n,
  input  logic [IVL_W-1:0]         gap_ivl,
  output led_pat_pkg::phase_e      phase
);
  import led_pat_pkg::*;

  localparam logic [GRP_W-1:0] GRP_ONE = GRP_W'(1);

  logic [IVL_W-1:0] ivl_cnt;
  logic [IVL_W-1:0] last_idx;
  logic [GRP_W-1:0] cyc_cnt;
  logic             step;
  logic             ivl_done;
  logic             gap_due;
  logic             clear;

  always_comb begin
    unique case (phase)
      PH_DARK: last_idx = IVL_W'(eff_ticks(32'(off_ivl)) - 1);
      PH_GAP:  last_idx = IVL_W'(eff_ticks(32'(gap_ivl)) - 1);
      default: last_idx = IVL_W'(eff_ticks(32'(on_ivl)) - 1);
    endcase
  end

  assign clear    = restart | ~run;
  assign step     = run & tick;
  assign ivl_done = step & (ivl_cnt == last_idx);
  assign gap_due  = (group_n != '0) & (cyc_cnt == group_n - GRP_ONE);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      phase   <= PH_LIT;
      ivl_cnt <= '0;
      cyc_cnt <= '0;
    end else if (ivl_done) begin
      ivl_cnt <= '0;
      unique case (phase)
        PH_LIT: phase <= PH_DARK;
        PH_DARK: begin
          if (gap_due) begin
            phase   <= PH_GAP;
            cyc_cnt <= '0;
          end else begin
            phase   <= PH_LIT;
            cyc_cnt <= (group_n == '0) ? '0 : cyc_cnt + GRP_ONE;
          end
        end
        default: phase <= PH_LIT;
      endcase
    end else if (step) begin
      ivl_cnt <= ivl_cnt + IVL_W'(1);
    end
  end

  assert_restart_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (phase == PH_LIT && ivl_cnt == '0 && cyc_cnt == '0));

  assert_still_without_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> ($stable(phase) && $stable(ivl_cnt)));

  assert_cnt_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ivl_cnt <= last_idx);

  assert_no_gap_when_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (group_n == '0) |-> (phase != PH_GAP));

  assert_gap_after_dark_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GAP && $past(phase) != PH_GAP) |-> ($past(phase) == PH_DARK));

endmodule

// File: rtl/led_pattern_gen.sv
module led_pattern_gen #(
  parameter int IVL_W = 8,
  parameter int GRP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [1:0]       wr_mode,
  input  logic [IVL_W-1:0] wr_on,
  input  logic [IVL_W-1:0] wr_off,
  input  logic [GRP_W-1:0] wr_group,
  input  logic [IVL_W-1:0] wr_gap,
  input  logic             blank,
  output logic             led,
  output logic             busy
);
  import led_pat_pkg::*;

  logic [1:0]       mode;
  logic [IVL_W-1:0] on_ivl, off_ivl, gap_ivl;
  logic [GRP_W-1:0] group_n;
  phase_e           phase;
  logic             flashing;

  led_cfg #(.IVL_W(IVL_W), .GRP_W(GRP_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_on(wr_on), .wr_off(wr_off), .wr_group(wr_group), .wr_gap(wr_gap),
    .mode(mode), .on_ivl(on_ivl), .off_ivl(off_ivl),
    .group_n(group_n), .gap_ivl(gap_ivl)
  );

  assign flashing = is_flash(mode) & ~blank;

  led_seq #(.IVL_W(IVL_W), .GRP_W(GRP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .restart(wr_en), .run(flashing), .tick(tick),
    .on_ivl(on_ivl), .off_ivl(off_ivl), .group_n(group_n), .gap_ivl(gap_ivl),
    .phase(phase)
  );

  assign led  = ~blank & ((mode == MODE_LIT) | (is_flash(mode) & (phase == PH_LIT)));
  assign busy = ~blank & (mode != MODE_DARK);

  assert_blank_dark_R8: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (!led && !busy));

  assert_led_implies_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    led |-> busy);

endmodule

// File: tb/led_pattern_gen_test.sv
`timescale 1ns/1ps
module led_pattern_gen_test;
  localparam int IVL_W = 8;
  localparam int GRP_W = 4;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0, blank = 0;
  logic [1:0] wr_mode = 0;
  logic [IVL_W-1:0] wr_on = 0, wr_off = 0, wr_gap = 0;
  logic [GRP_W-1:0] wr_group = 0;
  logic led, busy;

  int checks = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0, check_on = 0, tick_en = 0;
  int tdiv = 0;

  always #10 clk = ~clk;

  led_pattern_gen #(.IVL_W(IVL_W), .GRP_W(GRP_W)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_on(wr_on), .wr_off(wr_off), .wr_group(wr_group), .wr_gap(wr_gap),
    .blank(blank), .led(led), .busy(busy)
  );

  // Reference model: remaining-ticks countdown plus completed-cycle count.
  int m_mode, m_on, m_off, m_grp, m_gap, m_phase, m_rem, m_done;

  function automatic int len1(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_on = 0; m_off = 0; m_grp = 0; m_gap = 0;
      m_phase = 0; m_rem = 1; m_done = 0;
    end else if (wr_en) begin
      m_mode = wr_mode; m_on = wr_on; m_off = wr_off; m_grp = wr_group; m_gap = wr_gap;
      m_phase = 0; m_rem = len1(m_on); m_done = 0;
    end else if (blank || m_mode < 2) begin
      m_phase = 0; m_rem = len1(m_on); m_done = 0;
    end else if (tick) begin
      m_rem--;
      if (m_rem == 0) begin
        if (m_phase == 0) begin
          m_phase = 1; m_rem = len1(m_off);
        end else if (m_phase == 1) begin
          m_done++;
          if (m_grp != 0 && m_done == m_grp) begin
            m_phase = 2; m_rem = len1(m_gap); m_done = 0;
          end else begin
            m_phase = 0; m_rem = len1(m_on);
          end
        end else begin
          m_phase = 0; m_rem = len1(m_on);
        end
      end
    end
    #5;
    if (check_on) begin
      chk("led", int'(led), (!blank && (m_mode == 1 || (m_mode >= 2 && m_phase == 0))) ? 1 : 0);
      chk("busy", int'(busy), (!blank && m_mode != 0) ? 1 : 0);
    end
  end

  // Tick every third cycle while enabled.
  always @(negedge clk) begin
    if (tick_en) begin
      tdiv++;
      tick = (tdiv % 3 == 0);
    end else begin
      tick = 0;
    end
  end

  task automatic wr(int mode, int on, int off, int grp, int gap);
    @(negedge clk);
    wr_mode = 2'(mode); wr_on = IVL_W'(on); wr_off = IVL_W'(off);
    wr_group = GRP_W'(grp); wr_gap = IVL_W'(gap); wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic run(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    cur_req = "R1";
    check_on = 1;
    run(3);
    rst_n = 1;
    run(4);
    tick_en = 1;
    run(10);
    cur_req = "R2 R10";
    wr(1, 3, 3, 0, 0);
    run(20);
    wr(0, 3, 3, 0, 0);
    run(15);
    cur_req = "R3 R5";
    wr(2, 3, 2, 0, 0);
    run(200);
    cur_req = "R4";
    wr(3, 2, 1, 3, 5);
    run(300);
    cur_req = "R6";
    wr(2, 0, 0, 2, 0);
    run(100);
    cur_req = "R7";
    wr(2, 4, 4, 2, 3);
    run(37);
    wr(2, 4, 4, 2, 3);
    run(50);
    wr(2, 1, 6, 1, 2);
    run(60);
    cur_req = "R8";
    blank = 1;
    run(40);
    cur_req = "R9";
    wr(2, 2, 3, 2, 4);
    run(10);
    blank = 0;
    run(150);
    cur_req = "R8 R10";
    wr(1, 1, 1, 0, 0);
    run(5);
    blank = 1;
    run(10);
    blank = 0;
    run(10);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule